// File: doc/BRIEF.md
# Memory Ordering Issue Gate

This unit sits in front of the memory-issue stage of a core. Each cycle the core may present one memory operation, tagged with its ordering class. The gate grants it or holds it back, based on two saturating counts of reads and writes that are still in flight, a flag left behind by a write-only fence, and a slot that tracks one outstanding synchronization operation. When a request is held, a stall-cause code names the condition that blocks it.

Plain reads and writes flow freely between ordering points and may complete in any order. A full fence and a weak-ordering sync drain everything older before they issue. A write-only fence lets reads pass and holds only later writes. Acquire and release each order one direction: an acquire does not wait for older traffic but blocks all younger traffic until it completes. A release waits for older traffic but lets younger plain traffic go, in the eager-release style. Completion of sync, acquire and release is signalled by a dedicated pulse. The reserved class code 7 is handled like a full fence.

Top module: `mem_order_gate`

## Requirements
- R1: After reset both in-flight counts are zero, no fence flag is armed and the sync slot is free, so a full fence (class 2), a write fence (class 3) and a write (class 1) are each granted at once.
- R2: A plain read (class 0) is granted when nothing blocks it. Once RD_DEPTH reads are in flight, a further read is held with cause 1 until a read completes.
- R3: Once WR_DEPTH writes are in flight, a further write is held with cause 2 (write buffer full) until a write completes.
- R4: When a read or write is granted in the same cycle as a completion of the same kind, and that count is nonzero, the count stays the same.
- R5: A full fence is held with cause 3 (drain) while any read or write is in flight. It is granted in the first cycle where both counts are zero.
- R6: A write fence (class 3) is granted at once. After it, writes are held with cause 4 until every write issued before it has completed, while reads still issue.
- R7: A sync (class 4) is held with cause 3 until both counts are zero. Once granted, every request is held with cause 5 until a sync_done pulse.
- R8: An acquire (class 5) is granted while older reads and writes are still in flight. After it, every request is held with cause 5 until sync_done.
- R9: A release (class 6) is held with cause 3 until both counts are zero. Once granted, later plain reads and writes issue without waiting for it.
- R10: While a release is outstanding, a new release, acquire or sync is held with cause 6 until sync_done. This cause outranks cause 3.
- R11: With req_valid low, grant and stall_cause are both 0. With req_valid high, grant is 1 exactly when stall_cause is 0. Cause priority is 5, then 6, then 3, then 4, then 1, then 2.
- R12: A completion pulse that arrives while its count is zero is ignored and does not wrap the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A memory operation is presented this cycle |
| req_class | input | 3 | Ordering class of the presented operation |
| rd_done | input | 1 | One in-flight read has completed |
| wr_done | input | 1 | One in-flight write has completed |
| sync_done | input | 1 | The outstanding sync, acquire or release has completed |
| grant | output | 1 | The presented operation issues this cycle |
| stall_cause | output | 3 | Reason the presented operation is held, 0 when granted or idle |

## Verification
The assertions take for granted that the core keeps a held request presented and only counts an operation as issued on a cycle where grant is high. They also assume that class 7 is never used, and that sync_done refers to the one tracked synchronization operation. The stimulus respects this. It only pulses rd_done or wr_done against operations the reference model knows to be in flight, except for the deliberate pulses at zero that R12 calls for. It drives sync_done only after a sync, acquire or release has been granted, except for one idle pulse.

// File: rtl/mem_order_gate_pkg.sv
package mem_order_gate_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_FULL  = 3'd2,
        OP_WBAR  = 3'd3,
        OP_SYNC  = 3'd4,
        OP_ACQ   = 3'd5,
        OP_REL   = 3'd6,
        OP_RSVD  = 3'd7
    } op_class_e;

    typedef enum logic [2:0] {
        ST_NONE    = 3'd0,
        ST_RD_FULL = 3'd1,
        ST_WR_FULL = 3'd2,
        ST_DRAIN   = 3'd3,
        ST_WBAR    = 3'd4,
        ST_HOLD    = 3'd5,
        ST_SLOT    = 3'd6
    } stall_e;

    typedef enum logic [1:0] {
        SL_IDLE  = 2'd0,
        SL_BLOCK = 2'd1,
        SL_REL   = 2'd2
    } slot_e;

    // Operations that take the single synchronization slot.
    function automatic logic takes_slot(op_class_e c);
        return (c == OP_SYNC) || (c == OP_ACQ) || (c == OP_REL);
    endfunction

    // Operations that block all younger traffic until they complete.
    function automatic logic blocks_younger(op_class_e c);
        return (c == OP_SYNC) || (c == OP_ACQ);
    endfunction

    // Operations that must see every older read and write complete first.
    function automatic logic needs_drain(op_class_e c);
        return (c == OP_FULL) || (c == OP_SYNC) || (c == OP_REL) || (c == OP_RSVD);
    endfunction

endpackage

// File: rtl/mem_order_cnt.sv
module mem_order_cnt #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty
);
    logic up, dn;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign up    = inc && !full;
    assign dn    = dec && !empty;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (up && !dn)
            cnt <= cnt + CW'(1);
        else if (dn && !up)
            cnt <= cnt - CW'(1);
    end
endmodule

// File: rtl/mem_order_decide.sv
module mem_order_decide
    import mem_order_gate_pkg::*;
(
    input  logic      valid,
    input  op_class_e cls,
    input  logic      rd_empty,
    input  logic      rd_full,
    input  logic      wr_empty,
    input  logic      wr_full,
    input  logic      wbar_armed,
    input  slot_e     slot,
    output logic      grant,
    output stall_e    cause
);
    always_comb begin
        cause = ST_NONE;
        if (!valid)
            cause = ST_NONE;
        else if (slot == SL_BLOCK)
            cause = ST_HOLD;
        else if (takes_slot(cls) && slot == SL_REL)
            cause = ST_SLOT;
        else if (needs_drain(cls) && !(rd_empty && wr_empty))
            cause = ST_DRAIN;
        else if (cls == OP_WRITE && wbar_armed)
            cause = ST_WBAR;
        else if (cls == OP_READ && rd_full)
            cause = ST_RD_FULL;
        else if (cls == OP_WRITE && wr_full)
            cause = ST_WR_FULL;
        grant = valid && (cause == ST_NONE);
    end
endmodule

// File: rtl/mem_order_track.sv
module mem_order_track
    import mem_order_gate_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          grant,
    input  op_class_e     cls,
    input  logic          sync_done,
    input  logic [CW-1:0] wr_cnt,
    input  logic          wr_inc,
    input  logic          wr_done,
    output logic          wbar_armed,
    output slot_e         slot
);
    logic wr_zero_nx;

    // Write count after this edge is zero.
    assign wr_zero_nx = !wr_inc &&
                        ((wr_cnt == '0) || (wr_cnt == CW'(1) && wr_done));

    always_ff @(posedge clk) begin
        if (rst) begin
            wbar_armed <= 1'b0;
            slot       <= SL_IDLE;
        end else begin
            wbar_armed <= (wbar_armed || (grant && cls == OP_WBAR)) && !wr_zero_nx;
            if (grant && blocks_younger(cls))
                slot <= SL_BLOCK;
            else if (grant && cls == OP_REL)
                slot <= SL_REL;
            else if (sync_done)
                slot <= SL_IDLE;
        end
    end
endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate
    import mem_order_gate_pkg::*;
#(
    parameter int RD_DEPTH = 4,
    parameter int WR_DEPTH = 8,
    localparam int RD_CW = $clog2(RD_DEPTH + 1),
    localparam int WR_CW = $clog2(WR_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [2:0] req_class,
    input  logic       rd_done,
    input  logic       wr_done,
    input  logic       sync_done,
    output logic       grant,
    output logic [2:0] stall_cause
);
    op_class_e        cls;
    stall_e           cause;
    slot_e            slot;
    logic             wbar_armed;
    logic [RD_CW-1:0] rd_cnt;
    logic [WR_CW-1:0] wr_cnt;
    logic             rd_full, rd_empty, wr_full, wr_empty;
    logic             rd_inc, wr_inc;

    assign cls         = op_class_e'(req_class);
    assign stall_cause = cause;
    assign rd_inc      = grant && cls == OP_READ;
    assign wr_inc      = grant && cls == OP_WRITE;

    mem_order_cnt #(.DEPTH(RD_DEPTH)) u_rd_cnt (
        .clk(clk), .rst(rst), .inc(rd_inc), .dec(rd_done),
        .cnt(rd_cnt), .full(rd_full), .empty(rd_empty)
    );

    mem_order_cnt #(.DEPTH(WR_DEPTH)) u_wr_cnt (
        .clk(clk), .rst(rst), .inc(wr_inc), .dec(wr_done),
        .cnt(wr_cnt), .full(wr_full), .empty(wr_empty)
    );

    mem_order_decide u_decide (
        .valid(req_valid), .cls(cls),
        .rd_empty(rd_empty), .rd_full(rd_full),
        .wr_empty(wr_empty), .wr_full(wr_full),
        .wbar_armed(wbar_armed), .slot(slot),
        .grant(grant), .cause(cause)
    );

    mem_order_track #(.CW(WR_CW)) u_track (
        .clk(clk), .rst(rst), .grant(grant), .cls(cls),
        .sync_done(sync_done), .wr_cnt(wr_cnt), .wr_inc(wr_inc),
        .wr_done(wr_done), .wbar_armed(wbar_armed), .slot(slot)
    );
endmodule

// File: rtl/mem_order_gate_chk.sv
module mem_order_gate_chk
    import mem_order_gate_pkg::*;
#(
    parameter int RD_DEPTH = 4,
    parameter int WR_DEPTH = 8,
    localparam int RD_CW = $clog2(RD_DEPTH + 1),
    localparam int WR_CW = $clog2(WR_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [2:0]       req_class,
    input logic             rd_done,
    input logic             grant,
    input logic [2:0]       stall_cause,
    input logic [RD_CW-1:0] rd_cnt,
    input logic [WR_CW-1:0] wr_cnt,
    input logic             wbar_armed,
    input slot_e            slot
);
    p_rd_bound_r2: assert property (@(posedge clk) disable iff (rst)
        rd_cnt <= RD_CW'(RD_DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        wr_cnt <= WR_CW'(WR_DEPTH));

    p_balance_r4: assert property (@(posedge clk) disable iff (rst)
        (grant && req_class == OP_READ && rd_done && rd_cnt != '0)
        |=> (rd_cnt == $past(rd_cnt)));

    p_drained_r5: assert property (@(posedge clk) disable iff (rst)
        (grant && (req_class == OP_FULL || req_class == OP_SYNC || req_class == OP_REL))
        |-> (rd_cnt == '0 && wr_cnt == '0));

    p_wbar_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (wbar_armed && req_valid && req_class == OP_WRITE) |-> !grant);

    p_block_after_r7: assert property (@(posedge clk) disable iff (rst)
        (grant && (req_class == OP_SYNC || req_class == OP_ACQ)) |=> !grant);

    p_slot_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (slot == SL_REL && req_valid &&
         (req_class == OP_REL || req_class == OP_ACQ || req_class == OP_SYNC))
        |-> (!grant && stall_cause == ST_SLOT));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!grant && stall_cause == ST_NONE));
endmodule

bind mem_order_gate mem_order_gate_chk #(
    .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
    .rd_done(rd_done), .grant(grant), .stall_cause(stall_cause),
    .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .wbar_armed(wbar_armed), .slot(slot)
);

// File: tb/tb_mem_order_gate.sv
`timescale 1ns/1ps
module tb_mem_order_gate;
    localparam int RDD = 4;
    localparam int WRD = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_class = 3'd0;
    logic       rd_done = 1'b0, wr_done = 1'b0, sync_done = 1'b0;
    logic       grant;
    logic [2:0] stall_cause;

    int  checks = 0, errs = 0;
    bit  finished = 1'b0;

    // Reference state: in-flight counts, write-fence flag, slot (0 free, 1 blocking, 2 release)
    int  m_rd = 0, m_wr = 0, m_slot = 0;
    bit  m_wbar = 1'b0;

    always #2 clk = ~clk;

    mem_order_gate #(.RD_DEPTH(RDD), .WR_DEPTH(WRD)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .rd_done(rd_done), .wr_done(wr_done), .sync_done(sync_done),
        .grant(grant), .stall_cause(stall_cause)
    );

    task automatic step(input bit v, input int cls, input bit rdd, input bit wrd,
                        input bit sd, input string tag);
        int  ec;
        bit  eg;
        @(negedge clk);
        req_valid = v; req_class = cls[2:0];
        rd_done = rdd; wr_done = wrd; sync_done = sd;
        #1;
        ec = 0;
        if (v) begin
            if (m_slot == 1) ec = 5;
            else if ((cls == 4 || cls == 5 || cls == 6) && m_slot == 2) ec = 6;
            else if ((cls == 2 || cls == 4 || cls == 6) && (m_rd != 0 || m_wr != 0)) ec = 3;
            else if (cls == 1 && m_wbar) ec = 4;
            else if (cls == 0 && m_rd == RDD) ec = 1;
            else if (cls == 1 && m_wr == WRD) ec = 2;
        end
        eg = v && ec == 0;
        checks++;
        if (grant !== eg) begin
            errs++;
            $display("FAIL %s grant: actual=%0b expected=%0b (class %0d)", tag, grant, eg, cls);
        end
        checks++;
        if (stall_cause !== ec[2:0]) begin
            errs++;
            $display("FAIL %s stall_cause: actual=%0d expected=%0d (class %0d)", tag, stall_cause, ec, cls);
        end
        @(posedge clk);
        begin
            int nrd, nwr;
            nrd = m_rd + ((eg && cls == 0) ? 1 : 0) - ((rdd && m_rd > 0) ? 1 : 0);
            nwr = m_wr + ((eg && cls == 1) ? 1 : 0) - ((wrd && m_wr > 0) ? 1 : 0);
            m_wbar = (m_wbar || (eg && cls == 3)) && nwr != 0;
            if (eg && (cls == 4 || cls == 5)) m_slot = 1;
            else if (eg && cls == 6) m_slot = 2;
            else if (sd) m_slot = 0;
            m_rd = nrd; m_wr = nwr;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        step(0, 0, 0, 0, 0, "R11");
        step(1, 2, 0, 0, 0, "R1");
        step(1, 3, 0, 0, 0, "R1");
        step(1, 1, 0, 0, 0, "R1");
        step(0, 0, 0, 1, 0, "R11");

        // read saturation and balanced issue/complete
        for (int i = 0; i < RDD; i++) step(1, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, "R2");
        step(1, 0, 1, 0, 0, "R2");
        step(1, 0, 1, 0, 0, "R4");
        step(1, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, "R2");
        for (int i = 0; i < RDD; i++) step(0, 0, 1, 0, 0, "R2");

        // write saturation
        for (int i = 0; i < WRD; i++) step(1, 1, 0, 0, 0, "R3");
        step(1, 1, 0, 0, 0, "R3");
        step(1, 1, 0, 1, 0, "R3");
        step(1, 1, 0, 1, 0, "R4");

        // full fence drains writes
        step(1, 2, 0, 0, 0, "R5");
        for (int i = 0; i < WRD - 1; i++) step(1, 2, 0, 1, 0, "R5");
        step(1, 2, 0, 0, 0, "R5");

        // write fence lets reads pass
        step(1, 1, 0, 0, 0, "R6");
        step(1, 1, 0, 0, 0, "R6");
        step(1, 3, 0, 0, 0, "R6");
        step(1, 1, 0, 0, 0, "R6");
        step(1, 0, 0, 0, 0, "R6");
        step(1, 1, 0, 1, 0, "R6");
        step(1, 1, 0, 1, 0, "R6");
        step(1, 1, 0, 0, 0, "R6");
        step(0, 0, 1, 1, 0, "R6");

        // sync
        step(1, 0, 0, 0, 0, "R7");
        step(1, 4, 0, 0, 0, "R7");
        step(1, 4, 1, 0, 0, "R7");
        step(1, 4, 0, 0, 0, "R7");
        step(1, 0, 0, 0, 0, "R7");
        step(1, 1, 0, 0, 0, "R7");
        step(1, 0, 0, 0, 1, "R7");
        step(1, 0, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 0, "R7");

        // acquire
        step(1, 1, 0, 0, 0, "R8");
        step(1, 5, 0, 0, 0, "R8");
        step(1, 1, 0, 0, 0, "R8");
        step(1, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 1, "R8");
        step(1, 1, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 1, 0, "R8");

        // release
        step(1, 1, 0, 0, 0, "R9");
        step(1, 6, 0, 0, 0, "R9");
        step(1, 6, 0, 1, 0, "R9");
        step(1, 6, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, "R9");
        step(1, 1, 0, 0, 0, "R9");
        step(1, 6, 0, 0, 0, "R10");
        step(1, 5, 0, 0, 0, "R10");
        step(1, 4, 0, 0, 0, "R10");
        step(0, 0, 1, 1, 1, "R10");
        step(1, 5, 0, 0, 0, "R10");
        step(1, 6, 0, 0, 1, "R10");
        step(1, 6, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 1, "R10");

        // completions at zero are ignored
        step(0, 0, 1, 1, 0, "R12");
        step(0, 0, 1, 1, 1, "R12");
        for (int i = 0; i < RDD; i++) step(1, 0, 0, 0, 0, "R12");
        step(1, 0, 0, 0, 0, "R12");
        step(1, 2, 0, 0, 0, "R11");
        for (int i = 0; i < RDD; i++) step(0, 0, 1, 0, 0, "R12");
        step(0, 3, 0, 0, 0, "R11");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule